// File: doc/BRIEF.md
# Register-Mapped Program Counter Branch Unit

This block decides every change of control flow in a pipeline that interleaves up to four hardware tasks. Each task owns its own program counter, and software reaches that counter through two reserved register addresses. The two aliases differ only in what happens to work already in the pipe. A write to the flushing alias redirects the task and discards that task's younger instructions. A write to the delayed alias redirects the task and lets the instructions already fetched finish. Moves, adds and subtracts aimed at either alias give absolute and relative jumps.

The block also handles three dedicated branch operations. The first is a call that leaves its return address in a per-task link register. The second is a return that jumps indirectly through that register. The third is a decrement-and-branch that takes a sign-extended relative offset. The commit stage presents one retiring instruction per cycle. The fetch stage names the task it fetches for. The block returns the fetch address, a redirect strobe and a squash mask over the younger pipeline stages. It also exposes every task's counter and link register.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset every task counter and every link register reads zero, and the redirect strobe and the squash mask are low.
- R2: With fetch enabled, the fetch address equals the counter of the named task. That counter rises by one at the next clock edge, and the other counters hold.
- R3: Commit operation codes 1 (move), 2 (add) and 3 (subtract) aimed at register 0x1F0 load the committing task's counter at the next edge. The move loads the zero-extended immediate. The add loads the instruction's own address plus the zero-extended immediate, and the subtract loads that address minus it. The redirect strobe is high in the commit cycle.
- R4: A flushing redirect sets squash bit i in the commit cycle exactly when stage i is valid and that stage's task field equals the committing task. Stage i's task field is bits [2i+1:2i] of the pipeline task bus.
- R5: The same three operations aimed at register 0x1F1 load the counter with the same targets as R3 and raise the redirect strobe, while the squash mask stays all zero.
- R6: Move, add or subtract aimed at any other register leaves every counter and link register unchanged and raises neither the redirect strobe nor any squash bit.
- R7: A call (code 4) writes its own address plus one into the committing task's link register and loads the counter with the zero-extended immediate. It squashes as in R4, and other tasks' link registers hold.
- R8: A return (code 5) loads the committing task's counter with that task's link register and squashes as in R4.
- R9: A decrement-and-branch (code 6) whose count operand is not one branches to its own address plus the sign-extended 9-bit immediate and squashes as in R4. With a count of exactly one it has no effect.
- R10: A redirect never sets a squash bit for a stage of another task or for an invalid stage, and it never changes another task's counter.
- R11: When fetch and a redirect name the same task in one cycle, the redirect target wins and no increment is applied. A fetch for a different task still increments.
- R12: Codes 0 and 7 have no effect, whatever register they name.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fetchEn | input | 1 | Fetch slot used this cycle |
| fetchTask | input | 2 | Task fetching this cycle |
| fetchPc | output | 12 | Counter of the fetching task |
| cmtValid | input | 1 | An instruction retires this cycle |
| cmtTask | input | 2 | Task of the retiring instruction |
| cmtOp | input | 3 | Branch-class operation code |
| cmtDest | input | 9 | Destination register address |
| cmtImm | input | 9 | Immediate operand |
| cmtPc | input | 12 | Address of the retiring instruction |
| cmtCount | input | 16 | Count operand before decrement |
| pipeValid | input | 4 | Valid bit of each younger stage |
| pipeTask | input | 8 | Task field of each younger stage, two bits each |
| squashMask | output | 4 | Stages to invalidate this cycle |
| redirect | output | 1 | A counter load commits this cycle |
| taskPc | output | 48 | All task counters, task t at bits [12t+11:12t] |
| taskLink | output | 48 | All link registers, same layout |

## Verification
A wrong squash decision shows on the mask in the same cycle as the commit. The bench therefore samples it before the clock edge with a pipeline holding mixed tasks and invalid stages. A wrong target, a lost increment or a link register written for the wrong task shows on the counter and link buses one edge later. All eight of those registers are compared after every cycle, so even a corruption of an uninvolved task is caught at once and not left to surface at a later fetch.

// File: rtl/pc_branch_pkg.sv
package pc_branch_pkg;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_MOV  = 3'd1,
    OP_ADD  = 3'd2,
    OP_SUB  = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5,
    OP_DJNZ = 3'd6,
    OP_RSVD = 3'd7
  } brOp_t;

  typedef enum logic [2:0] {
    TGT_ABS  = 3'd0,
    TGT_ADD  = 3'd1,
    TGT_SUB  = 3'd2,
    TGT_REL  = 3'd3,
    TGT_LINK = 3'd4
  } tgtSel_t;

  // Strobes from control to datapath and squash logic.
  typedef struct packed {
    logic    take;
    logic    flush;
    logic    saveLink;
    tgtSel_t tgtSel;
  } brStrobe_t;

endpackage

// File: rtl/pc_branch_ctrl.sv
module pc_branch_ctrl
  import pc_branch_pkg::*;
#(
  parameter int unsigned REG_W      = 9,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FLUSH_ADDR = 'h1F0,
  parameter int unsigned DELAY_ADDR = 'h1F1
) (
  input  logic             cmtValid,
  input  logic [2:0]       cmtOp,
  input  logic [REG_W-1:0] cmtDest,
  input  logic [CNT_W-1:0] cmtCount,
  output brStrobe_t        strb
);

  localparam logic [REG_W-1:0] FlushAddr = REG_W'(FLUSH_ADDR);
  localparam logic [REG_W-1:0] DelayAddr = REG_W'(DELAY_ADDR);

  logic isFlushDest;
  logic isPcDest;
  logic countLive;

  assign isFlushDest = (cmtDest == FlushAddr);
  assign isPcDest    = isFlushDest || (cmtDest == DelayAddr);
  // Branch unless the decrement lands on zero.
  assign countLive   = (cmtCount != CNT_W'(1));

  always_comb begin
    strb        = '0;
    strb.tgtSel = TGT_ABS;
    if (cmtValid) begin
      case (brOp_t'(cmtOp))
        OP_MOV: begin
          strb.take   = isPcDest;
          strb.flush  = isFlushDest;
          strb.tgtSel = TGT_ABS;
        end
        OP_ADD: begin
          strb.take   = isPcDest;
          strb.flush  = isFlushDest;
          strb.tgtSel = TGT_ADD;
        end
        OP_SUB: begin
          strb.take   = isPcDest;
          strb.flush  = isFlushDest;
          strb.tgtSel = TGT_SUB;
        end
        OP_CALL: begin
          strb.take     = 1'b1;
          strb.flush    = 1'b1;
          strb.saveLink = 1'b1;
          strb.tgtSel   = TGT_ABS;
        end
        OP_RET: begin
          strb.take   = 1'b1;
          strb.flush  = 1'b1;
          strb.tgtSel = TGT_LINK;
        end
        OP_DJNZ: begin
          strb.take   = countLive;
          strb.flush  = countLive;
          strb.tgtSel = TGT_REL;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/pc_branch_dpath.sv
module pc_branch_dpath
  import pc_branch_pkg::*;
#(
  parameter int unsigned NTASK = 4,
  parameter int unsigned PC_W  = 12,
  parameter int unsigned IMM_W = 9,
  localparam int unsigned TID_W = $clog2(NTASK)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  brStrobe_t             strb,
  input  logic [TID_W-1:0]      cmtTask,
  input  logic [IMM_W-1:0]      cmtImm,
  input  logic [PC_W-1:0]       cmtPc,
  input  logic                  fetchEn,
  input  logic [TID_W-1:0]      fetchTask,
  output logic [PC_W-1:0]       fetchPc,
  output logic [NTASK*PC_W-1:0] taskPcFlat,
  output logic [NTASK*PC_W-1:0] taskLinkFlat
);

  localparam int unsigned EXT_W = PC_W - IMM_W;

  logic [PC_W-1:0] pcQ   [NTASK];
  logic [PC_W-1:0] linkQ [NTASK];
  logic [PC_W-1:0] immZero;
  logic [PC_W-1:0] immSign;
  logic [PC_W-1:0] target;
  logic [PC_W-1:0] retAddr;

  assign immZero = {{EXT_W{1'b0}}, cmtImm};
  assign immSign = {{EXT_W{cmtImm[IMM_W-1]}}, cmtImm};
  assign retAddr = cmtPc + PC_W'(1);

  always_comb begin
    case (strb.tgtSel)
      TGT_ADD:  target = cmtPc + immZero;
      TGT_SUB:  target = cmtPc - immZero;
      TGT_REL:  target = cmtPc + immSign;
      TGT_LINK: target = linkQ[cmtTask];
      default:  target = immZero;
    endcase
  end

  assign fetchPc = pcQ[fetchTask];

  for (genvar t = 0; t < NTASK; t++) begin : g_task
    logic ownCommit;
    logic ownFetch;
    assign ownCommit = (cmtTask == TID_W'(t));
    assign ownFetch  = fetchEn && (fetchTask == TID_W'(t));

    // Redirect outranks the sequential step of the same task.
    always_ff @(posedge clk) begin
      if (!rstN) begin
        pcQ[t] <= '0;
      end else if (strb.take && ownCommit) begin
        pcQ[t] <= target;
      end else if (ownFetch) begin
        pcQ[t] <= pcQ[t] + PC_W'(1);
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        linkQ[t] <= '0;
      end else if (strb.saveLink && ownCommit) begin
        linkQ[t] <= retAddr;
      end
    end

    assign taskPcFlat[t*PC_W +: PC_W]   = pcQ[t];
    assign taskLinkFlat[t*PC_W +: PC_W] = linkQ[t];
  end

endmodule

// File: rtl/pc_branch_squash.sv
module pc_branch_squash #(
  parameter int unsigned NSTAGE = 4,
  parameter int unsigned TID_W  = 2
) (
  input  logic                    flush,
  input  logic [TID_W-1:0]        cmtTask,
  input  logic [NSTAGE-1:0]       pipeValid,
  input  logic [NSTAGE*TID_W-1:0] pipeTask,
  output logic [NSTAGE-1:0]       squashMask
);

  for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
    assign squashMask[s] = flush && pipeValid[s]
                           && (pipeTask[s*TID_W +: TID_W] == cmtTask);
  end

endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pc_branch_pkg::*;
#(
  parameter int unsigned NTASK      = 4,
  parameter int unsigned NSTAGE     = 4,
  parameter int unsigned PC_W       = 12,
  parameter int unsigned IMM_W      = 9,
  parameter int unsigned REG_W      = 9,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FLUSH_ADDR = 'h1F0,
  parameter int unsigned DELAY_ADDR = 'h1F1
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              fetchEn,
  input  logic [$clog2(NTASK)-1:0]          fetchTask,
  output logic [PC_W-1:0]                   fetchPc,
  input  logic                              cmtValid,
  input  logic [$clog2(NTASK)-1:0]          cmtTask,
  input  logic [2:0]                        cmtOp,
  input  logic [REG_W-1:0]                  cmtDest,
  input  logic [IMM_W-1:0]                  cmtImm,
  input  logic [PC_W-1:0]                   cmtPc,
  input  logic [CNT_W-1:0]                  cmtCount,
  input  logic [NSTAGE-1:0]                 pipeValid,
  input  logic [NSTAGE*$clog2(NTASK)-1:0]   pipeTask,
  output logic [NSTAGE-1:0]                 squashMask,
  output logic                              redirect,
  output logic [NTASK*PC_W-1:0]             taskPc,
  output logic [NTASK*PC_W-1:0]             taskLink
);

  localparam int unsigned TID_W = $clog2(NTASK);

  brStrobe_t strb;

  pc_branch_ctrl #(
    .REG_W(REG_W), .CNT_W(CNT_W),
    .FLUSH_ADDR(FLUSH_ADDR), .DELAY_ADDR(DELAY_ADDR)
  ) u_ctrl (
    .cmtValid(cmtValid), .cmtOp(cmtOp), .cmtDest(cmtDest),
    .cmtCount(cmtCount), .strb(strb)
  );

  pc_branch_dpath #(
    .NTASK(NTASK), .PC_W(PC_W), .IMM_W(IMM_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmtTask(cmtTask),
    .cmtImm(cmtImm), .cmtPc(cmtPc), .fetchEn(fetchEn),
    .fetchTask(fetchTask), .fetchPc(fetchPc),
    .taskPcFlat(taskPc), .taskLinkFlat(taskLink)
  );

  pc_branch_squash #(
    .NSTAGE(NSTAGE), .TID_W(TID_W)
  ) u_squash (
    .flush(strb.flush), .cmtTask(cmtTask), .pipeValid(pipeValid),
    .pipeTask(pipeTask), .squashMask(squashMask)
  );

  assign redirect = strb.take;

endmodule

// File: rtl/pc_branch_unit_chk.sv
module pc_branch_unit_chk
  import pc_branch_pkg::*;
#(
  parameter int unsigned NTASK      = 4,
  parameter int unsigned NSTAGE     = 4,
  parameter int unsigned PC_W       = 12,
  parameter int unsigned REG_W      = 9,
  parameter int unsigned CNT_W      = 16,
  parameter int unsigned FLUSH_ADDR = 'h1F0,
  parameter int unsigned DELAY_ADDR = 'h1F1,
  localparam int unsigned TID_W = $clog2(NTASK)
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    fetchEn,
  input logic [TID_W-1:0]        fetchTask,
  input logic [PC_W-1:0]         fetchPc,
  input logic                    cmtValid,
  input logic [TID_W-1:0]        cmtTask,
  input logic [2:0]              cmtOp,
  input logic [REG_W-1:0]        cmtDest,
  input logic [PC_W-1:0]         cmtPc,
  input logic [CNT_W-1:0]        cmtCount,
  input logic [NSTAGE-1:0]       pipeValid,
  input logic [NSTAGE*TID_W-1:0] pipeTask,
  input logic [NSTAGE-1:0]       squashMask,
  input logic                    redirect,
  input logic [NTASK*PC_W-1:0]   taskPc,
  input logic [NTASK*PC_W-1:0]   taskLink
);

  logic [TID_W-1:0] cmtTaskQ;
  logic [TID_W-1:0] fetchTaskQ;
  logic [PC_W-1:0]  cmtPcQ;
  logic [PC_W-1:0]  fetchPcQ;
  logic [PC_W-1:0]  linkNowQ;
  logic [PC_W-1:0]  linkNow;
  logic             pcWriteOp;
  logic             pcDest;

  assign linkNow   = taskLink[cmtTask*PC_W +: PC_W];
  assign pcWriteOp = (cmtOp == OP_MOV) || (cmtOp == OP_ADD) || (cmtOp == OP_SUB);
  assign pcDest    = (cmtDest == REG_W'(FLUSH_ADDR)) || (cmtDest == REG_W'(DELAY_ADDR));

  always_ff @(posedge clk) begin
    cmtTaskQ   <= cmtTask;
    fetchTaskQ <= fetchTask;
    cmtPcQ     <= cmtPc;
    fetchPcQ   <= fetchPc;
    linkNowQ   <= linkNow;
  end

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    fetchEn && !(redirect && cmtTask == fetchTask)
    |=> taskPc[fetchTaskQ*PC_W +: PC_W] == fetchPcQ + PC_W'(1));

  p_delay_keep_r5: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid && pcWriteOp && cmtDest == REG_W'(DELAY_ADDR)
    |-> redirect && squashMask == '0);

  p_quiet_nonpc_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid && pcWriteOp && !pcDest |-> !redirect && squashMask == '0);

  p_call_link_r7: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid && cmtOp == OP_CALL
    |=> taskLink[cmtTaskQ*PC_W +: PC_W] == cmtPcQ + PC_W'(1));

  p_ret_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid && cmtOp == OP_RET |=> taskPc[cmtTaskQ*PC_W +: PC_W] == linkNowQ);

  p_djnz_last_r9: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid && cmtOp == OP_DJNZ && cmtCount == CNT_W'(1) |-> !redirect);

  p_nop_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    cmtValid && (cmtOp == OP_NOP || cmtOp == OP_RSVD)
    |-> !redirect && squashMask == '0);

  for (genvar s = 0; s < NSTAGE; s++) begin : g_own
    p_squash_own_r10: assert property (@(posedge clk) disable iff (!rstN)
      squashMask[s] |-> redirect && pipeValid[s]
                        && pipeTask[s*TID_W +: TID_W] == cmtTask);
  end

endmodule

bind pc_branch_unit pc_branch_unit_chk #(
  .NTASK(NTASK), .NSTAGE(NSTAGE), .PC_W(PC_W), .REG_W(REG_W),
  .CNT_W(CNT_W), .FLUSH_ADDR(FLUSH_ADDR), .DELAY_ADDR(DELAY_ADDR)
) u_chk (
  .clk(clk), .rstN(rstN), .fetchEn(fetchEn), .fetchTask(fetchTask),
  .fetchPc(fetchPc), .cmtValid(cmtValid), .cmtTask(cmtTask),
  .cmtOp(cmtOp), .cmtDest(cmtDest), .cmtPc(cmtPc), .cmtCount(cmtCount),
  .pipeValid(pipeValid), .pipeTask(pipeTask), .squashMask(squashMask),
  .redirect(redirect), .taskPc(taskPc), .taskLink(taskLink)
);

// File: tb/pc_branch_unit_tb.sv
`timescale 1ns/1ps
module pc_branch_unit_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        fetchEn;
  logic [1:0]  fetchTask;
  logic [11:0] fetchPc;
  logic        cmtValid;
  logic [1:0]  cmtTask;
  logic [2:0]  cmtOp;
  logic [8:0]  cmtDest;
  logic [8:0]  cmtImm;
  logic [11:0] cmtPc;
  logic [15:0] cmtCount;
  logic [3:0]  pipeValid;
  logic [7:0]  pipeTask;
  logic [3:0]  squashMask;
  logic        redirect;
  logic [47:0] taskPc;
  logic [47:0] taskLink;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [11:0] refPc   [4];
  logic [11:0] refLink [4];

  always #4 clk = ~clk;

  pc_branch_unit u_dut (
    .clk(clk), .rstN(rstN), .fetchEn(fetchEn), .fetchTask(fetchTask),
    .fetchPc(fetchPc), .cmtValid(cmtValid), .cmtTask(cmtTask),
    .cmtOp(cmtOp), .cmtDest(cmtDest), .cmtImm(cmtImm), .cmtPc(cmtPc),
    .cmtCount(cmtCount), .pipeValid(pipeValid), .pipeTask(pipeTask),
    .squashMask(squashMask), .redirect(redirect), .taskPc(taskPc),
    .taskLink(taskLink)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chkState(input string tag);
    for (int t = 0; t < 4; t++) begin
      chk({tag, " pc"},   32'(taskPc[t*12 +: 12]),   32'(refPc[t]));
      chk({tag, " link"}, 32'(taskLink[t*12 +: 12]), 32'(refLink[t]));
    end
  endtask

  // One cycle: drive, check same-cycle outputs, clock, check registers.
  task automatic step(input string tag, input bit fe, input logic [1:0] ft,
                      input bit cv, input logic [1:0] ct, input logic [2:0] op,
                      input logic [8:0] dest, input logic [8:0] imm,
                      input logic [11:0] cpc, input logic [15:0] cnt,
                      input logic [3:0] pv, input logic [7:0] pt);
    bit          take, flush, isPc;
    logic [11:0] tgt;
    logic [3:0]  expMask;
    @(negedge clk);
    fetchEn = fe; fetchTask = ft; cmtValid = cv; cmtTask = ct; cmtOp = op;
    cmtDest = dest; cmtImm = imm; cmtPc = cpc; cmtCount = cnt;
    pipeValid = pv; pipeTask = pt;
    take = 0; flush = 0; tgt = '0;
    isPc = (dest == 9'h1F0) || (dest == 9'h1F1);
    if (cv) begin
      case (op)
        3'd1: begin take = isPc; flush = (dest == 9'h1F0); tgt = {3'b0, imm}; end
        3'd2: begin take = isPc; flush = (dest == 9'h1F0); tgt = cpc + {3'b0, imm}; end
        3'd3: begin take = isPc; flush = (dest == 9'h1F0); tgt = cpc - {3'b0, imm}; end
        3'd4: begin take = 1; flush = 1; tgt = {3'b0, imm}; end
        3'd5: begin take = 1; flush = 1; tgt = refLink[ct]; end
        3'd6: begin take = (cnt != 16'd1); flush = take; tgt = cpc + {{3{imm[8]}}, imm}; end
        default: ;
      endcase
    end
    for (int s = 0; s < 4; s++)
      expMask[s] = flush && pv[s] && (pt[s*2 +: 2] == ct);
    #1;
    chk({tag, " redirect"}, 32'(redirect), 32'(take));
    chk({tag, " squash"}, 32'(squashMask), 32'(expMask));
    if (fe) chk({tag, " fetchPc"}, 32'(fetchPc), 32'(refPc[ft]));
    @(posedge clk);
    if (cv && op == 3'd4) refLink[ct] = cpc + 12'd1;
    if (take) refPc[ct] = tgt;
    if (fe && !(take && ct == ft)) refPc[ft] = refPc[ft] + 12'd1;
    #1;
    chkState(tag);
  endtask

  task automatic t_reset();
    rstN = 0; fetchEn = 0; fetchTask = 0; cmtValid = 0; cmtTask = 0;
    cmtOp = 0; cmtDest = 0; cmtImm = 0; cmtPc = 0; cmtCount = 0;
    pipeValid = 0; pipeTask = 0;
    for (int t = 0; t < 4; t++) begin refPc[t] = '0; refLink[t] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; #1;
    chkState("R1 reset");
    chk("R1 reset redirect", 32'(redirect), 0);
    chk("R1 reset squash", 32'(squashMask), 0);
  endtask

  task automatic t_fetch();
    step("R2 fetch", 1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2 fetch", 1, 2'd1, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2 fetch", 1, 2'd3, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2 fetch", 1, 2'd0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2 fetch", 1, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    step("R2 idle",  0, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_flushBranch();
    // stages: 0->task1, 1->task0, 2->task1, 3->task3
    step("R3 R4 mov 1F0", 0, 0, 1, 2'd1, 3'd1, 9'h1F0, 9'h155, 12'h020, 0, 4'b1111, 8'b11_01_00_01);
    step("R3 R4 add 1F0", 1, 2'd0, 1, 2'd2, 3'd2, 9'h1F0, 9'h1FF, 12'h100, 0, 4'b1011, 8'b10_10_10_00);
    step("R3 R4 sub 1F0 wrap", 0, 0, 1, 2'd0, 3'd3, 9'h1F0, 9'h005, 12'h003, 0, 4'b0111, 8'b00_00_01_00);
  endtask

  task automatic t_delayBranch();
    step("R5 mov 1F1", 0, 0, 1, 2'd3, 3'd1, 9'h1F1, 9'h0AA, 12'h000, 0, 4'b1111, 8'b11_11_11_11);
    step("R5 add 1F1", 1, 2'd3, 1, 2'd1, 3'd2, 9'h1F1, 9'h010, 12'h7F0, 0, 4'b1111, 8'b01_01_01_01);
    step("R5 sub 1F1", 0, 0, 1, 2'd2, 3'd3, 9'h1F1, 9'h001, 12'h400, 0, 4'b1111, 8'b10_10_10_10);
  endtask

  task automatic t_otherDest();
    step("R6 dest 1EF", 0, 0, 1, 2'd1, 3'd1, 9'h1EF, 9'h033, 12'h011, 0, 4'b1111, 8'b01_01_01_01);
    step("R6 dest 1F2", 0, 0, 1, 2'd2, 3'd2, 9'h1F2, 9'h033, 12'h011, 0, 4'b1111, 8'b10_10_10_10);
    step("R6 dest 000", 0, 0, 1, 2'd0, 3'd3, 9'h000, 9'h033, 12'h011, 0, 4'b1111, 8'b00_00_00_00);
  endtask

  task automatic t_callRet();
    step("R7 call", 0, 0, 1, 2'd3, 3'd4, 9'h000, 9'h080, 12'h040, 0, 4'b0101, 8'b00_11_01_11);
    step("R7 call other", 0, 0, 1, 2'd1, 3'd4, 9'h1F0, 9'h1C0, 12'hABC, 0, 4'b0000, 8'b0);
    step("R8 ret", 1, 2'd0, 1, 2'd3, 3'd5, 9'h000, 9'h000, 12'h081, 0, 4'b1100, 8'b11_00_00_00);
    step("R8 ret zero link", 0, 0, 1, 2'd2, 3'd5, 9'h000, 9'h000, 12'h300, 0, 4'b1111, 8'b10_01_10_00);
  endtask

  task automatic t_djnz();
    step("R9 djnz back", 0, 0, 1, 2'd0, 3'd6, 9'h000, 9'h1FF, 12'h010, 16'd5, 4'b0011, 8'b00_00_00_00);
    step("R9 djnz last", 0, 0, 1, 2'd0, 3'd6, 9'h000, 9'h1FF, 12'h010, 16'd1, 4'b0011, 8'b00_00_00_00);
    step("R9 djnz zero", 0, 0, 1, 2'd1, 3'd6, 9'h1F0, 9'h003, 12'hFFE, 16'd0, 4'b1111, 8'b01_00_01_00);
    step("R9 djnz max back", 0, 0, 1, 2'd2, 3'd6, 9'h000, 9'h100, 12'h050, 16'hFFFF, 4'b0000, 8'b0);
  endtask

  task automatic t_cross();
    step("R10 others only", 0, 0, 1, 2'd2, 3'd1, 9'h1F0, 9'h011, 12'h0, 0, 4'b1111, 8'b11_01_00_11);
    step("R10 invalid own", 0, 0, 1, 2'd3, 3'd1, 9'h1F0, 9'h022, 12'h0, 0, 4'b0000, 8'b11_11_11_11);
  endtask

  task automatic t_collide();
    step("R11 same task", 1, 2'd2, 1, 2'd2, 3'd1, 9'h1F0, 9'h0F0, 12'h0, 0, 4'b0001, 8'b10);
    step("R11 delayed same", 1, 2'd1, 1, 2'd1, 3'd2, 9'h1F1, 9'h004, 12'h100, 0, 4'b0001, 8'b01);
    step("R11 other task", 1, 2'd0, 1, 2'd3, 3'd4, 9'h000, 9'h044, 12'h200, 0, 4'b0001, 8'b11);
  endtask

  task automatic t_nop();
    step("R12 code0", 1, 2'd1, 1, 2'd1, 3'd0, 9'h1F0, 9'h077, 12'h5, 16'd9, 4'b1111, 8'b01_01_01_01);
    step("R12 code7", 0, 0, 1, 2'd0, 3'd7, 9'h1F0, 9'h077, 12'h5, 16'd9, 4'b1111, 8'b00_00_00_00);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_fetch();
    t_flushBranch();
    t_delayBranch();
    t_otherDest();
    t_callRet();
    t_djnz();
    t_cross();
    t_collide();
    t_nop();
    @(negedge clk);
    cmtValid = 0; fetchEn = 0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule